// File: doc/BRIEF.md
# Stream-Identifier Wrong-Path Squash Unit

This block recovers control flow in a decoupled in-order pipeline. There is no global flush. Every stage owns a one-bit path identifier, and every instruction carries the identifier that fetch held when the instruction entered. When the execute side resolves a branch as mispredicted, it inverts its own identifier and captures the corrected target. The new identifier value then moves backward one stage per cycle. Each stage discards any arriving instruction whose tag differs from its local value, and the discard costs no slot and no cycle of the stage's output.

A redirect toward fetch is raised only once the changed identifier has reached the front stage. Fetch inverts its identifier on the cycle the redirect is accepted, so new-path instructions can never meet a stage that still holds the old value. No second mispredict can arise before that acceptance, because only old-tagged instructions reach execute in that time and they are all discarded. A one-bit tag therefore never aliases. Writeback is enabled only for instructions that execute actually consumed, so squashed instructions never touch the scoreboard or the register file.

Top module: `sid_squash_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, the fetch and execute identifiers (fe_tag, ex_tag) read 0, fe_ready is 1, and ex_valid, redirect_valid and commit_valid are 0.
- R2: fe_tag always equals the fetch identifier, and an instruction accepted from fetch (fe_valid and fe_ready) is tagged with that value. An instruction accepted in the same cycle as a redirect acceptance carries the old value.
- R3: A consume at execute (ex_valid and ex_ready) with ex_mispredict high inverts ex_tag on the next cycle and captures ex_target as the redirect address.
- R4: redirect_valid rises once the inverted identifier has reached the front stage. It then holds, with a stable redirect_pc equal to the captured target, until redirect_ready is high. fe_tag inverts on the cycle after that acceptance.
- R5: An instruction whose tag differs from the identifier of the stage it enters is discarded there. It is consumed without taking a slot and is never presented at the execute port.
- R6: commit_valid is high exactly on the cycle after each execute consume, with commit_data equal to the consumed data. Squashed instructions never produce a commit.
- R7: While a redirect is pending, ex_valid stays low, so no second mispredict can be raised before the first redirect is accepted.
- R8: Correct-path instructions reach the execute port in fetch order, with none lost or duplicated.
- R9: ex_mispredict has no effect unless ex_valid and ex_ready are both high. In that case ex_tag is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_valid | input | 1 | Fetch offers an instruction |
| fe_data | input | DATA_W | Instruction payload from fetch |
| fe_ready | output | 1 | Front stage accepts or discards the offered instruction |
| fe_tag | output | 1 | Current fetch path identifier |
| ex_valid | output | 1 | A correct-path instruction is presented to execute |
| ex_data | output | DATA_W | Payload presented to execute |
| ex_ready | input | 1 | Execute consumes the presented instruction |
| ex_mispredict | input | 1 | The consumed instruction is a mispredicted branch |
| ex_target | input | PC_W | Corrected fetch address for the mispredict |
| ex_tag | output | 1 | Execute path identifier |
| redirect_valid | output | 1 | Redirect toward fetch pending |
| redirect_pc | output | PC_W | Corrected address carried by the redirect |
| redirect_ready | input | 1 | Fetch accepts the redirect |
| commit_valid | output | 1 | Writeback and scoreboard update enable |
| commit_data | output | DATA_W | Payload of the committing instruction |

## Verification
The hardest situation to reach is a pipeline full of wrong-path instructions from two epochs in a row. That is a mispredict whose redirect is held off for a long time, followed at once by another mispredict on the first new-path instruction while old instructions are still being discarded in the middle stages. The stimulus runs phases with different odds: one holds redirect_ready low nearly all the time, and one marks every consumed instruction as a mispredict. Fetch keeps offering instructions throughout, including in redirect-accept cycles. A bench model tags each fetched instruction with its epoch and removes dead epochs, so every instruction at the execute port and at commit is compared against the surviving program order.

// File: rtl/sq_pkg.sv
package sq_pkg;

    // One-bit path identifier carried by every in-flight instruction.
    typedef logic sid_t;

    localparam sid_t SID_RESET = 1'b0;

    // True when an instruction tag belongs to a path a stage has abandoned.
    function automatic logic sid_stale(input sid_t tag, input sid_t local_id);
        return tag != local_id;
    endfunction

    function automatic sid_t sid_flip(input sid_t cur);
        return ~cur;
    endfunction

endpackage

// File: rtl/sq_fetch_tag.sv
module sq_fetch_tag
    import sq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sid_t front_sid,
    input  logic redirect_ready,
    output logic redirect_valid,
    output sid_t fetch_sid
);
    sid_t sid_q;

    // A redirect is pending while the front stage has moved to a path
    // fetch has not yet switched to.
    assign redirect_valid = sid_stale(front_sid, sid_q);
    assign fetch_sid      = sid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sid_q <= SID_RESET;
        end else if (redirect_valid && redirect_ready) begin
            sid_q <= sid_flip(sid_q);
        end
    end
endmodule

// File: rtl/sq_stage.sv
module sq_stage
    import sq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  sid_t              sid_in,
    output sid_t              sid_out,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  sid_t              in_tag,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output sid_t              out_tag,
    input  logic              out_ready
);
    logic              slot_v;
    logic [DATA_W-1:0] slot_d;
    sid_t              slot_t;
    sid_t              sid_q;
    logic              drop;
    logic              take;

    assign drop     = in_valid && sid_stale(in_tag, sid_q);
    assign take     = in_valid && !drop && (!slot_v || out_ready);
    assign in_ready = drop || !slot_v || out_ready;

    assign out_valid = slot_v;
    assign out_data  = slot_d;
    assign out_tag   = slot_t;
    assign sid_out   = sid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= 1'b0;
            slot_d <= '0;
            slot_t <= SID_RESET;
            sid_q  <= SID_RESET;
        end else begin
            // The identifier follows the downstream neighbour one cycle late.
            sid_q <= sid_in;
            if (take) begin
                slot_v <= 1'b1;
                slot_d <= in_data;
                slot_t <= in_tag;
            end else if (out_ready) begin
                slot_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sq_exec_gate.sv
module sq_exec_gate
    import sq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  sid_t              in_tag,
    output logic              in_ready,
    output logic              ex_valid,
    output logic [DATA_W-1:0] ex_data,
    input  logic              ex_ready,
    input  logic              ex_mispredict,
    input  logic [PC_W-1:0]   ex_target,
    output sid_t              ex_sid,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              commit_valid,
    output logic [DATA_W-1:0] commit_data
);
    sid_t              sid_q;
    logic [PC_W-1:0]   pc_q;
    logic              match;
    logic              consume;

    assign match    = in_valid && !sid_stale(in_tag, sid_q);
    assign ex_valid = match;
    assign ex_data  = in_data;
    assign in_ready = !match || ex_ready;
    assign consume  = match && ex_ready;

    assign ex_sid      = sid_q;
    assign redirect_pc = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sid_q        <= SID_RESET;
            pc_q         <= '0;
            commit_valid <= 1'b0;
            commit_data  <= '0;
        end else begin
            commit_valid <= consume;
            if (consume) begin
                commit_data <= in_data;
            end
            if (consume && ex_mispredict) begin
                sid_q <= sid_flip(sid_q);
                pc_q  <= ex_target;
            end
        end
    end
endmodule

// File: rtl/sid_squash_unit.sv
module sid_squash_unit
    import sq_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int PC_W       = 32,
    parameter int NUM_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fe_valid,
    input  logic [DATA_W-1:0] fe_data,
    output logic              fe_ready,
    output logic              fe_tag,
    output logic              ex_valid,
    output logic [DATA_W-1:0] ex_data,
    input  logic              ex_ready,
    input  logic              ex_mispredict,
    input  logic [PC_W-1:0]   ex_target,
    output logic              ex_tag,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc,
    input  logic              redirect_ready,
    output logic              commit_valid,
    output logic [DATA_W-1:0] commit_data
);
    localparam int LINKS = NUM_STAGES + 1;

    // Link k feeds stage k; link NUM_STAGES feeds the execute gate.
    logic              lk_valid [LINKS];
    logic [DATA_W-1:0] lk_data  [LINKS];
    sid_t              lk_tag   [LINKS];
    logic              lk_ready [LINKS];
    // sid_chain[k] is stage k's identifier; the last entry is execute's.
    sid_t              sid_chain [LINKS];
    sid_t              fetch_sid;

    sq_fetch_tag u_fetch (
        .clk            (clk),
        .rst            (rst),
        .front_sid      (sid_chain[0]),
        .redirect_ready (redirect_ready),
        .redirect_valid (redirect_valid),
        .fetch_sid      (fetch_sid)
    );

    assign lk_valid[0] = fe_valid;
    assign lk_data[0]  = fe_data;
    assign lk_tag[0]   = fetch_sid;
    assign fe_ready    = lk_ready[0];
    assign fe_tag      = fetch_sid;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        sq_stage #(.DATA_W(DATA_W)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .sid_in    (sid_chain[k+1]),
            .sid_out   (sid_chain[k]),
            .in_valid  (lk_valid[k]),
            .in_data   (lk_data[k]),
            .in_tag    (lk_tag[k]),
            .in_ready  (lk_ready[k]),
            .out_valid (lk_valid[k+1]),
            .out_data  (lk_data[k+1]),
            .out_tag   (lk_tag[k+1]),
            .out_ready (lk_ready[k+1])
        );
    end

    sq_exec_gate #(.DATA_W(DATA_W), .PC_W(PC_W)) u_exec (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (lk_valid[NUM_STAGES]),
        .in_data       (lk_data[NUM_STAGES]),
        .in_tag        (lk_tag[NUM_STAGES]),
        .in_ready      (lk_ready[NUM_STAGES]),
        .ex_valid      (ex_valid),
        .ex_data       (ex_data),
        .ex_ready      (ex_ready),
        .ex_mispredict (ex_mispredict),
        .ex_target     (ex_target),
        .ex_sid        (sid_chain[NUM_STAGES]),
        .redirect_pc   (redirect_pc),
        .commit_valid  (commit_valid),
        .commit_data   (commit_data)
    );

    assign ex_tag = sid_chain[NUM_STAGES];
endmodule

// File: rtl/sid_squash_chk.sv
module sid_squash_chk #(
    parameter int DATA_W = 16,
    parameter int PC_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              fe_tag,
    input logic              ex_valid,
    input logic              ex_ready,
    input logic              ex_mispredict,
    input logic              ex_tag,
    input logic              redirect_valid,
    input logic [PC_W-1:0]   redirect_pc,
    input logic              redirect_ready,
    input logic              commit_valid,
    input logic [DATA_W-1:0] commit_data
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!fe_tag && !ex_tag && !redirect_valid && !commit_valid));

    assert_tag_flip_R3: assert property (@(posedge clk) disable iff (rst)
        (ex_valid && ex_ready && ex_mispredict) |=> (ex_tag != $past(ex_tag)));

    assert_redirect_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && !redirect_ready) |=> (redirect_valid && $stable(redirect_pc)));

    assert_fetch_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && redirect_ready) |=> (fe_tag != $past(fe_tag)));

    assert_commit_source_R6: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> $past(ex_valid && ex_ready));

    assert_no_second_mispredict_R7: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> !ex_valid);

    assert_mispredict_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        !(ex_valid && ex_ready) |=> $stable(ex_tag));
endmodule

bind sid_squash_unit sid_squash_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fe_tag         (fe_tag),
    .ex_valid       (ex_valid),
    .ex_ready       (ex_ready),
    .ex_mispredict  (ex_mispredict),
    .ex_tag         (ex_tag),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .redirect_ready (redirect_ready),
    .commit_valid   (commit_valid),
    .commit_data    (commit_data)
);

// File: tb/tb_sid_squash_unit.sv
module tb_sid_squash_unit;
    localparam int DATA_W = 16;
    localparam int PC_W   = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              fe_valid;
    logic [DATA_W-1:0] fe_data;
    logic              fe_ready;
    logic              fe_tag;
    logic              ex_valid;
    logic [DATA_W-1:0] ex_data;
    logic              ex_ready;
    logic              ex_mispredict;
    logic [PC_W-1:0]   ex_target;
    logic              ex_tag;
    logic              redirect_valid;
    logic [PC_W-1:0]   redirect_pc;
    logic              redirect_ready;
    logic              commit_valid;
    logic [DATA_W-1:0] commit_data;

    sid_squash_unit #(.DATA_W(DATA_W), .PC_W(PC_W), .NUM_STAGES(3)) dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench model of the surviving program order.
    int live_seq[$];
    int live_ep[$];
    int seq        = 0;
    int epoch_cur  = 0;
    int killed_ep  = -1;
    int mp_cnt     = 0;
    logic [PC_W-1:0] exp_pc = '0;
    bit   prev_consume = 0;
    logic [DATA_W-1:0] prev_data = '0;

    function automatic logic [PC_W-1:0] target_of(input int s);
        return PC_W'(s * 3 + 32'h100);
    endfunction

    function automatic bit chance(input int pct);
        return ($urandom % 100) < pct;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus and checking. Inputs are driven and outputs
    // sampled after the falling edge.
    task automatic step(input int p_fe, input int p_ex, input int p_rr, input int p_mp);
        bit do_mp;
        bit fe_acc;
        bit ex_acc;
        bit rd_acc;
        @(negedge clk);
        // R6: commit mirrors the previous cycle's consume
        check(commit_valid == prev_consume, "R6 commit_valid", int'(commit_valid), int'(prev_consume));
        if (prev_consume)
            check(commit_data == prev_data, "R6 commit_data", int'(commit_data), int'(prev_data));
        // R2 and R3/R9: identifiers follow the model
        check(fe_tag == epoch_cur[0], "R2 fe_tag", int'(fe_tag), epoch_cur % 2);
        check(ex_tag == mp_cnt[0], "R3/R9 ex_tag", int'(ex_tag), mp_cnt % 2);

        fe_valid       = chance(p_fe);
        fe_data        = DATA_W'(seq);
        ex_ready       = chance(p_ex);
        redirect_ready = chance(p_rr);
        ex_target      = target_of(seq);
        ex_mispredict  = 1'b0;
        #1;
        fe_acc = fe_valid && fe_ready;
        ex_acc = ex_valid && ex_ready;
        rd_acc = redirect_valid && redirect_ready;

        if (ex_valid) begin
            // R5/R8: only the next surviving instruction may appear
            if (live_seq.size() == 0)
                check(1'b0, "R5 ex_valid with empty model", int'(ex_data), -1);
            else
                check(int'(ex_data) == live_seq[0], "R5/R8 ex_data", int'(ex_data), live_seq[0]);
            // R7: no presentation while a redirect is pending
            check(!redirect_valid, "R7 ex_valid during redirect", int'(redirect_valid), 0);
        end
        if (rd_acc)
            check(redirect_pc == exp_pc, "R4 redirect_pc", int'(redirect_pc), int'(exp_pc));

        if (ex_acc) begin
            do_mp = chance(p_mp);
        end else begin
            do_mp = chance(30);  // R9: stray mispredict, must be ignored
        end
        ex_mispredict = do_mp;

        // Model the coming clock edge.
        prev_consume = ex_acc;
        prev_data    = ex_data;
        if (ex_acc) begin
            int e;
            e = live_ep[0];
            void'(live_seq.pop_front());
            void'(live_ep.pop_front());
            if (do_mp) begin
                for (int i = live_seq.size() - 1; i >= 0; i--) begin
                    if (live_ep[i] == e) begin
                        live_seq.delete(i);
                        live_ep.delete(i);
                    end
                end
                killed_ep = e;
                mp_cnt++;
                exp_pc = ex_target;
            end
        end
        if (fe_acc) begin
            // R2: an instruction taken in the accept cycle still has the old epoch
            if (epoch_cur != killed_ep) begin
                live_seq.push_back(seq);
                live_ep.push_back(epoch_cur);
            end
            seq++;
        end
        if (rd_acc) epoch_cur++;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        fe_valid = 0; fe_data = '0; ex_ready = 0; ex_mispredict = 0;
        ex_target = '0; redirect_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(fe_ready == 1'b1, "R1 fe_ready", int'(fe_ready), 1);
        check(!ex_valid, "R1 ex_valid", int'(ex_valid), 0);
        check(!redirect_valid, "R1 redirect_valid", int'(redirect_valid), 0);
        check(!commit_valid, "R1 commit_valid", int'(commit_valid), 0);
        check(!fe_tag && !ex_tag, "R1 tags", int'({fe_tag, ex_tag}), 0);
        rst = 1'b0;

        // Balanced traffic.
        repeat (3000) step(70, 70, 60, 15);
        // Redirect held off almost always: long runs of discarded instructions.
        repeat (2500) step(90, 80, 3, 20);
        // Every consumed instruction mispredicts: back-to-back epochs.
        repeat (2500) step(80, 60, 50, 100);
        // Slow execute with full fetch: stages back up.
        repeat (2500) step(100, 15, 70, 10);
        // Drain.
        repeat (80) step(0, 100, 100, 0);
        // R8: nothing on the correct path was lost
        check(live_seq.size() == 0, "R8 drained", live_seq.size(), 0);
        check(!redirect_valid, "R4 redirect resolved", int'(redirect_valid), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule